// File: doc/BRIEF.md
# Second-Order Delta-Sigma Modulator for a Four-Level DAC

This block turns a stream of 13-bit signed audio samples into a two-bit code for a four-level DAC. One sample arrives on each pulse of a sample enable, nominally at 512 kHz. Each code carries a sign bit and a magnitude bit, and those two bits select one of four analog steps: -2, -1, +1 or +2. The loop holds no zero level, so every sample drives the output one way or the other. Over many samples, the average of the steps tracks the input value.

Two saturating integrators form the noise-shaping loop. The first stage accumulates the difference between the quantized feedback and the input. The second stage accumulates two terms: the freshly updated first-stage value divided by 32, and a second feedback term. The top four bits of the 12-bit second-stage state drive a decoder. The decoder gives both the registered output pair and the 3-bit feedback value. That feedback value enters stage one at weight 2048 and stage two at weight 64.

Top module: `sdm2_modulator`

## Requirements
- R1: A clock edge with `rst_n` low clears both integrators and drives `sgn_o` and `lvl_o` to 0. This holds even when `sample_en` is high on the same edge.
- R2: `sgn_o` and `lvl_o` are registered. They change only on a clock edge where `sample_en` is high, and they hold their value on every other edge.
- R3: The decoder reads the top nibble of the 12-bit stage-two state V and maps it as follows:
  - 0000 gives feedback -1, with `sgn_o`=0 and `lvl_o`=0.
  - 0001 to 0111 gives feedback -2, with `sgn_o`=0 and `lvl_o`=1.
  - 1111 gives feedback +1, with `sgn_o`=1 and `lvl_o`=0.
  - 1000 to 1110 gives feedback +2, with `sgn_o`=1 and `lvl_o`=1.
- R4: `sgn_o`=1 means a positive step and `lvl_o`=1 means a step of magnitude two. The internal feedback is the same step value held as a 3-bit two's-complement number (-2=110, -1=111, +1=001, +2=010).
- R5: On each enabled edge, the 16-bit stage-one state U becomes U + 2048*f - din, where f is the feedback. The result saturates to the range [-32768, 32767].
- R6: On the same edge, V becomes V + (U' >>> 5) + 64*f, where U' is the new stage-one value. The shift is arithmetic. The result saturates to the range [-2048, 2047].
- R7: The code loaded on an enabled edge is decoded from V as it stood before that edge's update. The first sample after reset therefore yields `sgn_o`=0 and `lvl_o`=0.
- R8: The integrators clamp and do not wrap. With `din` held at -4096, the output settles at -2 (`sgn_o`=0, `lvl_o`=1) and stays there.
- R9: From reset, N samples of a constant input x give output steps s_i whose sum satisfies |2048*sum(s_i) - N*x| <= 32768. The average step therefore tracks x/2048.
- R10: Idle cycles between enabled edges do not change the code sequence produced for a given input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Takes one input sample and advances the loop by one step |
| din | input | 13 | Signed input sample |
| sgn_o | output | 1 | Registered DAC sign bit (1 = positive) |
| lvl_o | output | 1 | Registered DAC magnitude bit (1 = two steps) |

## Verification
Reset and the sample enable can land on the same edge, and reset must win. The bench first drives the loop into a non-zero state: a full-scale negative run pins the output at -2. It then asserts reset while holding `sample_en` high for two edges. The bench expects the cleared code during reset and no sample consumed. It then expects the following samples to match a reference loop restarted from zero.

// File: rtl/sdm2_pkg.sv
// Shared types for the second-order delta-sigma modulator.
// Assumes feedback values are always one of -2, -1, +1, +2.
package sdm2_pkg;
    localparam int DX_W  = 3;
    localparam int NIB_W = 4;

    typedef logic signed [DX_W-1:0] dx_t;

    typedef struct packed {
        logic sgn;
        logic lvl;
    } dac_code_t;

    localparam dx_t DX_NEG2 = 3'sb110;
    localparam dx_t DX_NEG1 = 3'sb111;
    localparam dx_t DX_POS1 = 3'sb001;
    localparam dx_t DX_POS2 = 3'sb010;
endpackage

// File: rtl/sdm2_quant_dec.sv
// Four-level quantizer decoder.
// Maps the top nibble of the stage-two state to a signed feedback value
// and to the sign/magnitude DAC code. Purely combinational.
// Assumes the nibble is the sign-carrying top of a two's-complement state.
module sdm2_quant_dec
    import sdm2_pkg::*;
(
    input  logic [NIB_W-1:0] nib,
    output dx_t              dx,
    output dac_code_t        code
);
    // Threshold decode: zero and all-ones nibbles give unit steps, the rest give double steps.
    always_comb begin
        if (nib == '0) begin
            dx   = DX_NEG1;
            code = '{sgn: 1'b0, lvl: 1'b0};
        end else if (!nib[NIB_W-1]) begin
            dx   = DX_NEG2;
            code = '{sgn: 1'b0, lvl: 1'b1};
        end else if (nib == '1) begin
            dx   = DX_POS1;
            code = '{sgn: 1'b1, lvl: 1'b0};
        end else begin
            dx   = DX_POS2;
            code = '{sgn: 1'b1, lvl: 1'b1};
        end
    end
endmodule

// File: rtl/sdm2_sat_integ.sv
// Saturating accumulator with a one-sample delay register.
// acc_next is the clamped sum of the stored value and the addend. It is
// exposed so that a following stage can use the new value in the same cycle.
// Assumes ADD_W and ACC_W are at least 2.
module sdm2_sat_integ #(
    parameter int ACC_W = 16,
    parameter int ADD_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ADD_W-1:0] addend,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] acc_next
);
    localparam int SUM_W = ((ACC_W > ADD_W) ? ACC_W : ADD_W) + 1;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] SUM_MAX = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SUM_MIN = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] acc_ext;
    logic signed [SUM_W-1:0] add_ext;
    logic signed [SUM_W-1:0] sum_w;

    // Widen both operands so the raw sum cannot overflow before the clamp.
    always_comb begin
        acc_ext = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        add_ext = {{(SUM_W-ADD_W){addend[ADD_W-1]}}, addend};
        sum_w   = acc_ext + add_ext;
    end

    // Clamp the wide sum to the accumulator range.
    always_comb begin
        if (sum_w > SUM_MAX)      acc_next = ACC_MAX;
        else if (sum_w < SUM_MIN) acc_next = ACC_MIN;
        else                      acc_next = sum_w[ACC_W-1:0];
    end

    // Delay register: advances only on a sample, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_next;
    end

    // R2: the state must not move between samples.
    assert_state_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));

    // R8: a full accumulator pushed further upward stays at the top.
    assert_no_wrap_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_q == ACC_MAX && !addend[ADD_W-1]) |=> acc_q == ACC_MAX);

    // R8: an empty accumulator pushed further downward stays at the bottom.
    assert_no_wrap_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && acc_q == ACC_MIN && addend[ADD_W-1]) |=> acc_q == ACC_MIN);
endmodule

// File: rtl/sdm2_out_reg.sv
// Output register for the sign/magnitude DAC code.
// Loads a new code only on a sample, so the DAC sees a stable code for the
// whole sample period. Reset value is the cleared code.
module sdm2_out_reg
    import sdm2_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  dac_code_t code_d,
    output logic      sgn_q,
    output logic      lvl_q
);
    // Capture the decoded code on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sgn_q <= 1'b0;
            lvl_q <= 1'b0;
        end else if (en) begin
            sgn_q <= code_d.sgn;
            lvl_q <= code_d.lvl;
        end
    end

    // R1: reset clears the code whatever the enable does.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!sgn_q && !lvl_q));

    // R2: the code holds between samples.
    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(sgn_q) && $stable(lvl_q)));
endmodule

// File: rtl/sdm2_modulator.sv
// Second-order delta-sigma modulator producing a sign/magnitude code for a
// four-level DAC.
// Stage one integrates (feedback * 2^FB1_SH - din). Stage two integrates the
// new stage-one value shifted right by CAS_SH plus (feedback * 2^FB2_SH).
// The top nibble of the stage-two state picks the feedback and the output code.
// Assumes one sample_en pulse per sample period, with any number of idle
// cycles in between.
module sdm2_modulator
    import sdm2_pkg::*;
#(
    parameter int DIN_W  = 13,
    parameter int ACC1_W = 16,
    parameter int VX_W   = 12,
    parameter int FB1_SH = 11,
    parameter int FB2_SH = 6,
    parameter int CAS_SH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic [DIN_W-1:0] din,
    output logic             sgn_o,
    output logic             lvl_o
);
    localparam int A1_W     = ((DIN_W > FB1_SH + DX_W) ? DIN_W : FB1_SH + DX_W) + 1;
    localparam int A2_W     = ACC1_W + 1;
    localparam int NIB_SPAN = 1 << (VX_W - NIB_W);
    localparam logic signed [VX_W-1:0] VX_MAX = {1'b0, {(VX_W-1){1'b1}}};

    dx_t                      dx;
    dac_code_t                code;
    logic signed [A1_W-1:0]   dx1_ext;
    logic signed [A1_W-1:0]   din_ext;
    logic signed [A1_W-1:0]   add1;
    logic signed [ACC1_W-1:0] v1_q;
    logic signed [ACC1_W-1:0] v1_next;
    logic signed [A2_W-1:0]   v1n_ext;
    logic signed [A2_W-1:0]   dx2_ext;
    logic signed [A2_W-1:0]   add2;
    logic signed [VX_W-1:0]   v2_q;
    logic signed [VX_W-1:0]   v2_next;

    // Quantizer: only the top nibble of the stage-two state is decoded.
    sdm2_quant_dec u_dec (
        .nib  (v2_q[VX_W-1 -: NIB_W]),
        .dx   (dx),
        .code (code)
    );

    // Stage-one addend: scaled feedback minus the sign-extended input.
    always_comb begin
        dx1_ext = {{(A1_W-DX_W){dx[DX_W-1]}}, dx};
        din_ext = {{(A1_W-DIN_W){din[DIN_W-1]}}, din};
        add1    = (dx1_ext <<< FB1_SH) - din_ext;
    end

    sdm2_sat_integ #(.ACC_W(ACC1_W), .ADD_W(A1_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sample_en),
        .addend   (add1),
        .acc_q    (v1_q),
        .acc_next (v1_next)
    );

    // Stage-two addend: the new stage-one value scaled down, plus the lighter feedback.
    always_comb begin
        v1n_ext = {v1_next[ACC1_W-1], v1_next};
        dx2_ext = {{(A2_W-DX_W){dx[DX_W-1]}}, dx};
        add2    = (v1n_ext >>> CAS_SH) + (dx2_ext <<< FB2_SH);
    end

    sdm2_sat_integ #(.ACC_W(VX_W), .ADD_W(A2_W)) u_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sample_en),
        .addend   (add2),
        .acc_q    (v2_q),
        .acc_next (v2_next)
    );

    sdm2_out_reg u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (sample_en),
        .code_d (code),
        .sgn_q  (sgn_o),
        .lvl_q  (lvl_o)
    );

    // R3: a large positive state must yield a negative double step on the next code.
    assert_quant_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && v2_q >= NIB_SPAN) |=> (!sgn_o && lvl_o));

    // R3: a large negative state must yield a positive double step.
    assert_quant_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && v2_q < -NIB_SPAN) |=> (sgn_o && lvl_o));

    // R5: with zero input, a positive feedback raises a negative stage-one state.
    assert_stage1_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && din == '0 && !dx[DX_W-1] && v1_q < 0) |=> v1_q > $past(v1_q));

    // R6: a full stage-two state with a non-negative addend stays at its top.
    assert_stage2_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_q == VX_MAX && !add2[A2_W-1]) |-> v2_next == VX_MAX);
endmodule

// File: tb/sdm2_modulator_tb_top.sv
// Scoreboard bench: the driver pushes codes from an integer loop model,
// and the monitor pops and compares them after each enabled edge.
module sdm2_modulator_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_en = 1'b0;
    logic [12:0]       din = '0;
    logic              sgn_o;
    logic              lvl_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [1:0] exp_q[$];
    logic [1:0] act_log[$];
    logic [1:0] log_a[$];
    logic [1:0] cur_code = 2'b00;
    logic [1:0] mon_e;
    logic en_seen = 1'b0;
    logic rst_seen = 1'b0;
    int step_sum = 0;
    int m_v1 = 0;
    int m_v2 = 0;

    always #2 clk = ~clk;

    sdm2_modulator dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .din       (din),
        .sgn_o     (sgn_o),
        .lvl_o     (lvl_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // R4: code {sgn,lvl} to signed step.
    function automatic int code2step(input logic [1:0] c);
        int mag;
        mag = c[0] ? 2 : 1;
        return c[1] ? mag : -mag;
    endfunction

    function automatic logic [1:0] step2code(input int y);
        return {y > 0, (y == 2 || y == -2)};
    endfunction

    // R3: nibble thresholds of the 12-bit state, as value ranges.
    function automatic int quant(input int v);
        if (v >= 256) return -2;
        if (v >= 0)   return -1;
        if (v >= -256) return 1;
        return 2;
    endfunction

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    always @(posedge clk) begin
        en_seen  <= sample_en && rst_n;
        rst_seen <= rst_n;
    end

    // Monitor: pop one expected code per enabled edge; otherwise check the hold.
    always @(negedge clk) begin
        if (rst_seen) begin
            if (en_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "code with no expected sample", int'({sgn_o, lvl_o}), -1);
                end else begin
                    mon_e = exp_q.pop_front();
                    check({sgn_o, lvl_o} == mon_e, "R3 R5 R6 R7", "sample code",
                          int'({sgn_o, lvl_o}), int'(mon_e));
                    cur_code = mon_e;
                    step_sum += code2step({sgn_o, lvl_o});
                    act_log.push_back({sgn_o, lvl_o});
                end
            end else begin
                check({sgn_o, lvl_o} == cur_code, "R2", "held code",
                      int'({sgn_o, lvl_o}), int'(cur_code));
            end
        end
    end

    // Driver: one sample, model step (R5, R6), then idle cycles.
    task automatic apply(input int x, input int gap);
        int y;
        din       = 13'(x);
        sample_en = 1'b1;
        y    = quant(m_v2);
        m_v1 = clampi(m_v1 + 2048 * y - x, -32768, 32767);
        m_v2 = clampi(m_v2 + (m_v1 >>> 5) + 64 * y, -2048, 2047);
        exp_q.push_back(step2code(y));
        @(negedge clk);
        if (gap > 0) begin
            sample_en = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        sample_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R1: reset with the enable held high on the same edges.
    task automatic do_reset();
        rst_n     = 1'b0;
        sample_en = 1'b1;
        din       = 13'd1234;
        @(negedge clk);
        cur_code = 2'b00;
        exp_q.delete();
        m_v1 = 0;
        m_v2 = 0;
        @(negedge clk);
        check({sgn_o, lvl_o} == 2'b00, "R1", "code during reset with enable high",
              int'({sgn_o, lvl_o}), 0);
        rst_n     = 1'b1;
        sample_en = 1'b0;
        @(negedge clk);
        step_sum = 0;
        act_log.delete();
    endtask

    // R9: average step tracks a constant input.
    task automatic avg_phase(input int x, input int n, input int gap);
        int diff;
        do_reset();
        repeat (n) apply(x, gap);
        idle(3);
        diff = step_sum * 2048 - n * x;
        check(diff <= 32768 && diff >= -32768, "R9 R4", "2048*sum(steps) - N*x", diff, 0);
    endtask

    initial begin
        #(4 * 150000);
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        n_vec++;
        n_bad++;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R7: first sample after reset decodes the cleared state.
        apply(0, 2);
        idle(2);
        check(act_log.size() == 1 && act_log[0] == 2'b00, "R7", "first code after reset",
              (act_log.size() > 0) ? int'(act_log[0]) : -1, 0);

        avg_phase(0, 600, 0);
        avg_phase(1500, 600, 2);
        avg_phase(-2500, 600, 1);

        // Varied input with varied gaps, checked by the scoreboard.
        do_reset();
        for (int i = 0; i < 300; i++) apply(((i * 37) % 8191) - 4095, i % 3);
        idle(3);

        // R8: full-scale negative input pins the output at -2.
        do_reset();
        repeat (120) apply(-4096, 1);
        idle(2);
        check({sgn_o, lvl_o} == 2'b01, "R8", "code under full-scale negative input",
              int'({sgn_o, lvl_o}), 1);
        for (int i = 60; i < 120; i++)
            check(act_log[i] == 2'b01, "R8", "late code stays at -2", int'(act_log[i]), 1);

        // R1: reset from a non-zero state (covered by the check inside do_reset).
        // R10: the same inputs with and without idle gaps.
        do_reset();
        for (int i = 0; i < 48; i++) apply(((i * 977) % 6000) - 3000, 0);
        idle(3);
        log_a = act_log;
        do_reset();
        for (int i = 0; i < 48; i++) apply(((i * 977) % 6000) - 3000, 5);
        idle(3);
        check(act_log.size() == log_a.size(), "R10", "sample count", act_log.size(), log_a.size());
        for (int i = 0; i < 48; i++)
            check(act_log[i] == log_a[i], "R10", "code with gaps vs back-to-back",
                  int'(act_log[i]), int'(log_a[i]));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule